// File: doc/BRIEF.md
# External Interrupt Sense Unit

This block watches a group of external interrupt request pins and turns each one into an internal interrupt request. Every pin first passes through a two-stage synchronizer. A per-pin two-bit sense code then selects whether the request follows a low level on the pin, or whether it is raised by a falling edge, a rising edge, or an edge in either direction. In the edge modes the request is held in a sticky per-pin flag. Software clears that flag by writing a one to its bit in a status register.

The sense codes are packed two bits per pin into a control word that is twice the pin count wide. That word is reached as an upper byte and a lower byte on a small register bus, next to the status register. A standby input returns the sense codes and the flags to their reset state. A local reset synchronizer asserts reset asynchronously and releases it on a clock edge.

Top module: `ext_irq_sense`

## Requirements
- R1: The control word is 16 bits. Pin n uses bit 2n+1 as the upper sense bit and bit 2n as the lower sense bit. Bus address 0 reads and writes bits 15..8, which cover pins 7..4. Address 1 reads and writes bits 7..0, which cover pins 3..0. Both bytes read back exactly what was written.
- R2: After reset, all control bits and all flags are zero and reads at every address return 0. With the pins held high, `irq_req_o` is 0.
- R3: With sense code 00 (low level), `irq_req_o[n]` is 1 while the synchronized pin is low and 0 once it is high again. The request appears two clocks after the pin changes and is not latched.
- R4: With sense code 01 (falling edge), a high-to-low pin transition sets flag n, and `irq_req_o[n]` then stays 1. A rising transition sets nothing.
- R5: With sense code 10 (rising edge), a low-to-high transition sets flag n. A falling transition sets nothing.
- R6: With sense code 11 (both edges), a transition in either direction sets flag n.
- R7: Address 2 reads the eight flags, with bit n holding pin n. Writing there clears every flag whose write-data bit is 1 and leaves the flags whose write-data bit is 0 unchanged.
- R8: When an edge that sets a flag arrives in the same clock as a write that clears that flag, the flag ends up set.
- R9: Writing a new sense code never creates a request or sets a flag by itself. This holds even when the pin was already low or already high before the write.
- R10: While `standby_i` is high, the control word and all flags are forced to zero.
- R11: Reads at address 3 return 0, and writes to address 3 change no register.
- R12: In level mode, pin edges never set the pin's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| standby_i | input | 1 | Forces the sense codes and the flags to zero |
| irq_pin_i | input | 8 | Asynchronous external interrupt request pins |
| bus_addr_i | input | 2 | Register address: 0 control high byte, 1 control low byte, 2 flags, 3 unused |
| bus_we_i | input | 1 | Write strobe for the current address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for the current address (combinational) |
| irq_req_o | output | 8 | Per-pin interrupt request |

## Verification
The bench goes after a clear write that lands in the same clock as the edge that sets the flag. A design that lets the clear win would lose that interrupt. It also changes the sense code while a pin is already low or high. A design whose edge history does not track the pin across the write would raise a phantom request.

A design that latches the level request would keep the request asserted after the pin goes high again. A design that reverses the field order or the upper/lower bit roles would react to the wrong edge or on the wrong pin. The bench also checks partial clears, standby, and the unused address. A design that fails these would wipe pending flags it was not asked to clear, or would keep its settings through standby.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LEVEL_LOW = 2'b00,
    SENSE_FALL      = 2'b01,
    SENSE_RISE      = 2'b10,
    SENSE_DUAL      = 2'b11
  } sense_e;

  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL_HI = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL_LO = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS   = 2'd2;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned CHAIN_W = STAGES * WIDTH;

  logic [CHAIN_W-1:0] chain_d;
  logic [CHAIN_W-1:0] chain_q;

  // The pins idle high, so every stage resets to one.
  always_comb begin
    chain_d = {chain_q[CHAIN_W-WIDTH-1:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign sync_o = chain_q[CHAIN_W-1 -: WIDTH];

endmodule

// File: rtl/irq_sense_regs.sv
module irq_sense_regs
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  standby_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  we_i,
  input  logic [NUM_PINS-1:0]   wdata_i,
  input  logic [NUM_PINS-1:0]   flags_i,
  output logic [2*NUM_PINS-1:0] ctrl_o,
  output logic [NUM_PINS-1:0]   flag_clr_o,
  output logic [NUM_PINS-1:0]   rdata_o
);

  localparam int unsigned DATA_W = NUM_PINS;
  localparam int unsigned CTRL_W = 2 * NUM_PINS;

  logic [CTRL_W-1:0] ctrl_d;
  logic [CTRL_W-1:0] ctrl_q;
  logic              hi_wr;
  logic              lo_wr;
  logic              ctrl_en;

  assign hi_wr   = we_i && (addr_i == ADDR_CTRL_HI);
  assign lo_wr   = we_i && (addr_i == ADDR_CTRL_LO);
  assign ctrl_en = standby_i | hi_wr | lo_wr;

  always_comb begin
    ctrl_d = ctrl_q;
    if (standby_i) begin
      ctrl_d = '0;
    end else if (hi_wr) begin
      ctrl_d[CTRL_W-1 -: DATA_W] = wdata_i;
    end else if (lo_wr) begin
      ctrl_d[DATA_W-1:0] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  assign flag_clr_o = (we_i && (addr_i == ADDR_FLAGS)) ? wdata_i : '0;
  assign ctrl_o     = ctrl_q;

  always_comb begin
    case (addr_i)
      ADDR_CTRL_HI: rdata_o = ctrl_q[CTRL_W-1 -: DATA_W];
      ADDR_CTRL_LO: rdata_o = ctrl_q[DATA_W-1:0];
      ADDR_FLAGS:   rdata_o = flags_i;
      default:      rdata_o = '0;
    endcase
  end

  p_standby_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    standby_i |=> (ctrl_q == '0));

  p_hi_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_wr && !standby_i) |=> (ctrl_q[CTRL_W-1 -: DATA_W] == $past(wdata_i)));

  p_lo_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_wr && !standby_i) |=> (ctrl_q[DATA_W-1:0] == $past(wdata_i)));

  p_unused_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en) |=> $stable(ctrl_q));

endmodule

// File: rtl/irq_pin_detect.sv
module irq_pin_detect
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   standby_i,
  input  logic   sync_i,
  input  sense_e mode_i,
  input  logic   clr_i,
  output logic   flag_o,
  output logic   req_o
);

  logic prev_q;
  logic flag_d;
  logic flag_q;
  logic flag_en;
  logic rise;
  logic fall;
  logic edge_hit;

  // The previous sample follows the pin in every mode, so a mode write sees no stale edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
    end else begin
      prev_q <= sync_i;
    end
  end

  assign rise = sync_i & ~prev_q;
  assign fall = ~sync_i & prev_q;

  always_comb begin
    case (mode_i)
      SENSE_FALL: edge_hit = fall;
      SENSE_RISE: edge_hit = rise;
      SENSE_DUAL: edge_hit = rise | fall;
      default:    edge_hit = 1'b0;
    endcase
  end

  assign flag_en = standby_i | edge_hit | clr_i;

  // A new edge takes priority over a clear in the same cycle.
  always_comb begin
    flag_d = flag_q;
    if (standby_i) begin
      flag_d = 1'b0;
    end else if (edge_hit) begin
      flag_d = 1'b1;
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;
  assign req_o  = (mode_i == SENSE_LEVEL_LOW) ? ~sync_i : flag_q;

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && !standby_i) |=> flag_q);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !edge_hit && !standby_i) |=> !flag_q);

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !edge_hit) |=> !flag_q);

  p_level_no_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == SENSE_LEVEL_LOW && !flag_q) |=> !flag_q);

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        standby_i,
  input  logic [7:0]  irq_pin_i,
  input  logic [1:0]  bus_addr_i,
  input  logic        bus_we_i,
  input  logic [7:0]  bus_wdata_i,
  output logic [7:0]  bus_rdata_o,
  output logic [7:0]  irq_req_o
);

  localparam int unsigned NUM_PINS    = 8;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned CTRL_W      = 2 * NUM_PINS;

  logic [1:0]          rst_pipe_q;
  logic                rst_n_int;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] flags;
  logic [NUM_PINS-1:0] flag_clr;
  logic [CTRL_W-1:0]   ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_n_int = rst_pipe_q[1];

  irq_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) i_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .async_i (irq_pin_i),
    .sync_o  (pin_sync)
  );

  irq_sense_regs #(
    .NUM_PINS (NUM_PINS)
  ) i_regs (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .standby_i  (standby_i),
    .addr_i     (bus_addr_i),
    .we_i       (bus_we_i),
    .wdata_i    (bus_wdata_i),
    .flags_i    (flags),
    .ctrl_o     (ctrl),
    .flag_clr_o (flag_clr),
    .rdata_o    (bus_rdata_o)
  );

  for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
    sense_e mode;
    assign mode = sense_e'(ctrl[2*n+1 -: 2]);

    irq_pin_detect i_det (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .standby_i (standby_i),
      .sync_i    (pin_sync[n]),
      .mode_i    (mode),
      .clr_i     (flag_clr[n]),
      .flag_o    (flags[n]),
      .req_o     (irq_req_o[n])
    );
  end

  p_standby_flags_r10: assert property (@(posedge clk) disable iff (!rst_n_int)
    standby_i |=> (flags == '0));

endmodule

// File: tb/test_ext_irq_sense.sv
module test_ext_irq_sense;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       standby;
  logic [7:0] pins;
  logic [1:0] addr;
  logic       we;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic [7:0] req;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  ext_irq_sense i_ext_irq_sense (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby_i   (standby),
    .irq_pin_i   (pins),
    .bus_addr_i  (addr),
    .bus_we_i    (we),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_req_o   (req)
  );

  // Fields: [8:6] pin, [5:4] sense code, [3] start level, [2] end level, [1] expected request, [0] expected flag
  localparam int NVEC = 10;
  localparam logic [8:0] VEC [NVEC] = '{
    {3'd0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0},
    {3'd1, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd2, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1},
    {3'd3, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0},
    {3'd4, 2'b10, 1'b0, 1'b1, 1'b1, 1'b1},
    {3'd5, 2'b10, 1'b1, 1'b0, 1'b0, 1'b0},
    {3'd6, 2'b11, 1'b1, 1'b0, 1'b1, 1'b1},
    {3'd7, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1},
    {3'd0, 2'b11, 1'b0, 1'b1, 1'b1, 1'b1},
    {3'd7, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = 8'h00; addr = 2'd3;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; we = 1'b0;
    #1 d = rdata;
  endtask

  task automatic write_ctrl(input logic [15:0] w);
    bus_write(2'd0, w[15:8]);
    bus_write(2'd1, w[7:0]);
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; standby = 1'b0; pins = 8'hFF; addr = 2'd3; we = 1'b0; wdata = 8'h00;
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(4);

    // R2: reset state
    for (int a = 0; a < 4; a++) begin
      bus_read(2'(a), rd);
      chk("R2 reset read", 16'(rd), 16'h0);
    end
    chk("R2 reset req", 16'(req), 16'h0);

    // R1: byte readback
    bus_write(2'd0, 8'hA5);
    bus_write(2'd1, 8'h3C);
    bus_read(2'd0, rd); chk("R1 high byte", 16'(rd), 16'hA5);
    bus_read(2'd1, rd); chk("R1 low byte", 16'(rd), 16'h3C);
    write_ctrl(16'h0000);
    wait_cycles(4);

    // Table of per-pin sense cases (R3..R6, R12)
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0]  p;
      logic [1:0]  m;
      logic [15:0] w;
      p = VEC[v][8:6];
      m = VEC[v][5:4];
      w = 16'(m) << (2 * p);
      write_ctrl(w);
      @(negedge clk); pins[p] = VEC[v][3];
      wait_cycles(4);
      bus_write(2'd2, 8'hFF);
      wait_cycles(1);
      pins[p] = VEC[v][2];
      wait_cycles(4);
      chk(mode_tag(m), 16'(req), 16'(VEC[v][1]) << p);
      bus_read(2'd2, rd);
      chk(m == 2'b00 ? "R12 flag" : mode_tag(m), 16'(rd), 16'(VEC[v][0]) << p);
      write_ctrl(16'h0000);
      @(negedge clk); pins = 8'hFF;
      wait_cycles(4);
      bus_write(2'd2, 8'hFF);
    end

    // R3: level request not latched
    @(negedge clk); pins[0] = 1'b0;
    wait_cycles(3);
    chk("R3 level on", 16'(req[0]), 16'h1);
    pins[0] = 1'b1;
    wait_cycles(3);
    chk("R3 level off", 16'(req[0]), 16'h0);

    // R7: partial clear (pin2 falling, pin4 rising)
    write_ctrl(16'h0210);
    @(negedge clk); pins[2] = 1'b0; pins[4] = 1'b0;
    wait_cycles(4);
    bus_write(2'd2, 8'hFF);
    pins[4] = 1'b1;
    wait_cycles(4);
    @(negedge clk); pins[2] = 1'b1;
    wait_cycles(4);
    @(negedge clk); pins[2] = 1'b0;
    wait_cycles(4);
    bus_read(2'd2, rd); chk("R7 both set", 16'(rd), 16'h14);
    bus_write(2'd2, 8'h04);
    bus_read(2'd2, rd); chk("R7 clear pin2 only", 16'(rd), 16'h10);
    bus_write(2'd2, 8'h00);
    bus_read(2'd2, rd); chk("R7 zero write", 16'(rd), 16'h10);
    bus_write(2'd2, 8'hFF);
    write_ctrl(16'h0000);
    @(negedge clk); pins = 8'hFF;
    wait_cycles(4);

    // R8: edge and clear in the same cycle
    write_ctrl(16'h0004);          // pin1 falling
    @(negedge clk); pins[1] = 1'b0;
    @(posedge clk); @(posedge clk);
    bus_write(2'd2, 8'h02);        // clear lands on the edge that sets the flag
    bus_read(2'd2, rd); chk("R8 set wins", 16'(rd), 16'h02);
    chk("R8 req", 16'(req[1]), 16'h1);
    bus_write(2'd2, 8'h02);
    bus_read(2'd2, rd); chk("R8 later clear", 16'(rd), 16'h00);
    write_ctrl(16'h0000);
    @(negedge clk); pins = 8'hFF;
    wait_cycles(4);

    // R9: mode writes do not create requests
    @(negedge clk); pins[3] = 1'b0;
    wait_cycles(4);
    chk("R9 level before", 16'(req[3]), 16'h1);
    write_ctrl(16'h0040);          // pin3 falling while already low
    wait_cycles(4);
    chk("R9 req after falling write", 16'(req[3]), 16'h0);
    bus_read(2'd2, rd); chk("R9 flag falling", 16'(rd), 16'h00);
    write_ctrl(16'h0000);
    @(negedge clk); pins[3] = 1'b1;
    wait_cycles(4);
    write_ctrl(16'h00C0);          // pin3 both edges while high
    wait_cycles(4);
    bus_read(2'd2, rd); chk("R9 flag dual", 16'(rd), 16'h00);
    chk("R9 req dual", 16'(req), 16'h00);

    // R10: standby
    write_ctrl(16'h0080);          // pin3 rising
    @(negedge clk); pins[3] = 1'b0;
    wait_cycles(4);
    pins[3] = 1'b1;
    wait_cycles(4);
    write_ctrl(16'hBE80);
    bus_read(2'd2, rd); chk("R10 flag before", 16'(rd), 16'h08);
    @(negedge clk); standby = 1'b1;
    @(negedge clk); standby = 1'b0;
    bus_read(2'd0, rd); chk("R10 high cleared", 16'(rd), 16'h00);
    bus_read(2'd1, rd); chk("R10 low cleared", 16'(rd), 16'h00);
    bus_read(2'd2, rd); chk("R10 flags cleared", 16'(rd), 16'h00);

    // R11: unused address
    write_ctrl(16'h5A69);
    bus_write(2'd3, 8'hFF);
    bus_read(2'd3, rd); chk("R11 read zero", 16'(rd), 16'h00);
    bus_read(2'd0, rd); chk("R11 high kept", 16'(rd), 16'h5A);
    bus_read(2'd1, rd); chk("R11 low kept", 16'(rd), 16'h69);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule